// File: doc/BRIEF.md
# Trap Target Selection Unit

This block decides where the program counter goes when a core takes a trap while a core-local vectored interrupt controller is in charge. It samples a trap request, which carries a cause code, an exception-or-interrupt flag, the interrupt number and that interrupt's hardware-vectoring enable. It also samples two control register values: the trap base register, whose low two bits select the mode, and the vector table base register. From these it produces a single-cycle redirect carrying the new PC, the cause to record and a fault flag.

Two vectoring paths exist, and the path is chosen separately for each interrupt. A software-vectored interrupt, like any synchronous exception, goes to the trap base address, where a common dispatcher runs. A hardware-vectored interrupt skips the dispatcher. The block reads that interrupt's slot in the vector table through a simple memory read port, then jumps through the function pointer it gets back. Both paths use the same table of 32-bit pointers.

The dispatcher learns its handler from a companion value that the block computes all the time. That value is the table slot address of the currently selected pending interrupt. It is zero when there is nothing for the dispatcher to do.

Top module: `trap_vector_unit`

## Requirements
- R1: After reset, `busy`, `redirect_valid` and `mem_req` are all 0.
- R2: Controller mode is active when `trap_base[1:0]` is 2'b11. In this mode a synchronous exception (`trap_is_irq`=0) accepted on one edge gives a one-cycle `redirect_valid` after that edge. The pulse carries `redirect_pc` = `trap_base` with bits [1:0] cleared, `redirect_fault`=0 and `redirect_cause`=`trap_cause`. No memory request is made.
- R3: In controller mode, an interrupt whose `trap_hw_vec` is 0 is redirected in the same way as R2: to the trap base with bits [1:0] cleared, with its `trap_cause` passed through. No memory request is made.
- R4: When `trap_base[1:0]` is any value other than 2'b11, every trap goes to the trap base with bits [1:0] cleared. This includes an interrupt with `trap_hw_vec`=1. No memory request is made.
- R5: In controller mode, an interrupt with `trap_hw_vec`=1 raises `mem_req` for exactly one cycle after the accepting edge. The request carries `mem_addr` = (`vtab_base` with bits [5:0] cleared) + 4 × `trap_irq_id`.
- R6: After a response with `mem_rvalid`=1 and `mem_err`=0, the next cycle gives `redirect_valid`=1. The pulse carries `redirect_pc` = `mem_rdata` with bit 0 cleared, `redirect_fault`=0 and the cause of the original trap.
- R7: After a response with `mem_rvalid`=1 and `mem_err`=1, the next cycle gives `redirect_valid`=1. The pulse carries `redirect_pc` = the trap base with bits [1:0] cleared, `redirect_fault`=1 and `redirect_cause` = FAULT_CAUSE (default 1).
- R8: `busy` is 1 from the cycle after a hardware-vectored trap is accepted until the cycle its redirect is presented. Any trap request raised while `busy` is 1 is ignored: it produces no redirect and no memory request.
- R9: In controller mode, `next_entry` equals (`vtab_base` with bits [5:0] cleared) + 4 × `pend_irq_id` when `pend_valid`=1, `pend_level` > `level_thresh` and `pend_hw_vec`=0.
- R10: `next_entry` is 0 when `pend_valid`=0, when `pend_level` ≤ `level_thresh`, or when the block is not in controller mode.
- R11: `next_entry` is 0 when the selected pending interrupt has `pend_hw_vec`=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trap_valid | input | 1 | Trap request, sampled while not busy |
| trap_is_irq | input | 1 | 1 for an interrupt, 0 for a synchronous exception |
| trap_cause | input | CAUSE_W | Cause code to report with the redirect |
| trap_irq_id | input | ID_W | Interrupt number of the trap |
| trap_hw_vec | input | 1 | Hardware vectoring enabled for this interrupt |
| trap_base | input | XLEN | Trap base register; bits [1:0] select the mode |
| vtab_base | input | XLEN | Vector table base register; bits [5:0] ignored |
| pend_valid | input | 1 | A pending interrupt is selected |
| pend_irq_id | input | ID_W | Number of the selected pending interrupt |
| pend_level | input | LEVEL_W | Level of the selected pending interrupt |
| pend_hw_vec | input | 1 | Hardware vectoring enabled for the pending interrupt |
| level_thresh | input | LEVEL_W | Current level threshold |
| next_entry | output | XLEN | Table slot address for the dispatcher, or 0 |
| busy | output | 1 | Table fetch in progress; new traps are held off |
| mem_req | output | 1 | One-cycle table read request |
| mem_addr | output | XLEN | Table read address |
| mem_rvalid | input | 1 | Read response valid |
| mem_rdata | input | XLEN | Fetched function pointer |
| mem_err | input | 1 | Read response carries a bus error |
| redirect_valid | output | 1 | One-cycle PC redirect strobe |
| redirect_pc | output | XLEN | New program counter |
| redirect_fault | output | 1 | Redirect is an instruction access fault |
| redirect_cause | output | CAUSE_W | Cause code of the redirect |

## Verification
The bench pairs a hardware-vectored interrupt with an unaligned table base and the highest interrupt number. A design that did not mask the base, or that scaled the number wrongly, would fetch from the wrong slot. It also raises a trap while a fetch is outstanding: a design without the hold-off would give a second redirect or start an overlapping read. Bus error responses must fall back to the trap base with the fault flag set, and fetched pointers with bit 0 set must come back with that bit cleared. The dispatcher value is driven to the exact threshold-equal level and to a hardware-vectored pending interrupt; a design with an off-by-one compare or a missing vectoring check would return a non-zero slot address there.

// File: rtl/tvu_pkg.sv
package tvu_pkg;
    localparam logic [1:0] MODE_VECTORED_CTRL = 2'b11;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } tvu_state_e;
endpackage

// File: rtl/tvu_entry_addr.sv
module tvu_entry_addr #(
    parameter int XLEN      = 32,
    parameter int ID_W      = 8,
    parameter int TBL_ALIGN = 6
) (
    input  logic [XLEN-1:0] vtab_base,
    input  logic [ID_W-1:0] irq_id,
    output logic [XLEN-1:0] slot_addr
);
    localparam int PTR_SHIFT = $clog2(XLEN / 8);

    logic [XLEN-1:0] aligned_base;
    logic            unused_low;

    assign unused_low   = ^vtab_base[TBL_ALIGN-1:0];
    assign aligned_base = {vtab_base[XLEN-1:TBL_ALIGN], {TBL_ALIGN{1'b0}}};
    assign slot_addr    = aligned_base + (XLEN'(irq_id) << PTR_SHIFT);
endmodule

// File: rtl/tvu_next_entry.sv
module tvu_next_entry #(
    parameter int XLEN    = 32,
    parameter int LEVEL_W = 8
) (
    input  logic               ctrl_mode,
    input  logic               pend_valid,
    input  logic [LEVEL_W-1:0] pend_level,
    input  logic [LEVEL_W-1:0] level_thresh,
    input  logic               pend_hw_vec,
    input  logic [XLEN-1:0]    slot_addr,
    output logic [XLEN-1:0]    next_entry
);
    logic eligible;

    always_comb begin
        eligible   = ctrl_mode && pend_valid && (pend_level > level_thresh) && !pend_hw_vec;
        next_entry = eligible ? slot_addr : '0;
    end

    // R11
    always_comb begin
        hw_vec_zero_chk: assert (!(pend_hw_vec && (next_entry != '0)))
            else $error("next_entry non-zero for hardware-vectored pending interrupt");
    end

    // R10
    always_comb begin
        below_thresh_zero_chk: assert (!((pend_level <= level_thresh) && (next_entry != '0)))
            else $error("next_entry non-zero at or below threshold");
    end
endmodule

// File: rtl/tvu_fetch_ctrl.sv
module tvu_fetch_ctrl
    import tvu_pkg::*;
#(
    parameter int               XLEN        = 32,
    parameter int               CAUSE_W     = 12,
    parameter logic [CAUSE_W-1:0] FAULT_CAUSE = CAUSE_W'(1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               trap_valid,
    input  logic               trap_is_irq,
    input  logic [CAUSE_W-1:0] trap_cause,
    input  logic               trap_hw_vec,
    input  logic               ctrl_mode,
    input  logic [XLEN-1:0]    base_pc,
    input  logic [XLEN-1:0]    slot_addr,
    input  logic               mem_rvalid,
    input  logic [XLEN-1:0]    mem_rdata,
    input  logic               mem_err,
    output logic               busy,
    output logic               mem_req,
    output logic [XLEN-1:0]    mem_addr,
    output logic               redirect_valid,
    output logic [XLEN-1:0]    redirect_pc,
    output logic               redirect_fault,
    output logic [CAUSE_W-1:0] redirect_cause
);
    typedef struct packed {
        tvu_state_e         st;
        logic               req;
        logic [XLEN-1:0]    addr;
        logic               rv;
        logic [XLEN-1:0]    pc;
        logic               fault;
        logic [CAUSE_W-1:0] cause;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d       = r_q;
        r_d.req   = 1'b0;
        r_d.rv    = 1'b0;
        r_d.fault = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (trap_valid) begin
                    r_d.cause = trap_cause;
                    if (ctrl_mode && trap_is_irq && trap_hw_vec) begin
                        r_d.st   = ST_WAIT;
                        r_d.req  = 1'b1;
                        r_d.addr = slot_addr;
                    end else begin
                        r_d.rv = 1'b1;
                        r_d.pc = base_pc;
                    end
                end
            end
            ST_WAIT: begin
                if (mem_rvalid) begin
                    r_d.st = ST_IDLE;
                    r_d.rv = 1'b1;
                    if (mem_err) begin
                        r_d.pc    = base_pc;
                        r_d.fault = 1'b1;
                        r_d.cause = FAULT_CAUSE;
                    end else begin
                        r_d.pc = mem_rdata & ~XLEN'(1);
                    end
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, req: 1'b0, addr: '0, rv: 1'b0, pc: '0, fault: 1'b0, cause: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign busy           = (r_q.st == ST_WAIT);
    assign mem_req        = r_q.req;
    assign mem_addr       = r_q.addr;
    assign redirect_valid = r_q.rv;
    assign redirect_pc    = r_q.pc;
    assign redirect_fault = r_q.fault;
    assign redirect_cause = r_q.cause;

    // R5
    single_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req);

    // R8
    req_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> busy);

    // R8
    held_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !mem_rvalid) |=> (!redirect_valid && !mem_req));

    // R6
    ptr_jump_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && mem_rvalid && !mem_err) |=>
            (redirect_valid && !redirect_fault && redirect_pc == {$past(mem_rdata[XLEN-1:1]), 1'b0}));

    // R7
    bus_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && mem_rvalid && mem_err) |=>
            (redirect_valid && redirect_fault && redirect_pc == $past(base_pc)));

    // R4
    no_fetch_direct_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && trap_valid && !ctrl_mode) |=> (!mem_req && redirect_valid));
endmodule

// File: rtl/trap_vector_unit.sv
module trap_vector_unit
    import tvu_pkg::*;
#(
    parameter int               XLEN        = 32,
    parameter int               ID_W        = 8,
    parameter int               CAUSE_W     = 12,
    parameter int               LEVEL_W     = 8,
    parameter int               TBL_ALIGN   = 6,
    parameter logic [CAUSE_W-1:0] FAULT_CAUSE = CAUSE_W'(1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               trap_valid,
    input  logic               trap_is_irq,
    input  logic [CAUSE_W-1:0] trap_cause,
    input  logic [ID_W-1:0]    trap_irq_id,
    input  logic               trap_hw_vec,
    input  logic [XLEN-1:0]    trap_base,
    input  logic [XLEN-1:0]    vtab_base,
    input  logic               pend_valid,
    input  logic [ID_W-1:0]    pend_irq_id,
    input  logic [LEVEL_W-1:0] pend_level,
    input  logic               pend_hw_vec,
    input  logic [LEVEL_W-1:0] level_thresh,
    output logic [XLEN-1:0]    next_entry,
    output logic               busy,
    output logic               mem_req,
    output logic [XLEN-1:0]    mem_addr,
    input  logic               mem_rvalid,
    input  logic [XLEN-1:0]    mem_rdata,
    input  logic               mem_err,
    output logic               redirect_valid,
    output logic [XLEN-1:0]    redirect_pc,
    output logic               redirect_fault,
    output logic [CAUSE_W-1:0] redirect_cause
);
    localparam int N_LOOKUP = 2;

    logic            ctrl_mode;
    logic [XLEN-1:0] base_pc;
    logic [ID_W-1:0] lookup_id   [N_LOOKUP];
    logic [XLEN-1:0] lookup_addr [N_LOOKUP];

    assign ctrl_mode    = (trap_base[1:0] == MODE_VECTORED_CTRL);
    assign base_pc      = {trap_base[XLEN-1:2], 2'b00};
    assign lookup_id[0] = trap_irq_id;
    assign lookup_id[1] = pend_irq_id;

    for (genvar g = 0; g < N_LOOKUP; g++) begin : g_slot
        tvu_entry_addr #(
            .XLEN      (XLEN),
            .ID_W      (ID_W),
            .TBL_ALIGN (TBL_ALIGN)
        ) u_slot (
            .vtab_base (vtab_base),
            .irq_id    (lookup_id[g]),
            .slot_addr (lookup_addr[g])
        );
    end

    tvu_next_entry #(
        .XLEN    (XLEN),
        .LEVEL_W (LEVEL_W)
    ) u_next (
        .ctrl_mode    (ctrl_mode),
        .pend_valid   (pend_valid),
        .pend_level   (pend_level),
        .level_thresh (level_thresh),
        .pend_hw_vec  (pend_hw_vec),
        .slot_addr    (lookup_addr[1]),
        .next_entry   (next_entry)
    );

    tvu_fetch_ctrl #(
        .XLEN        (XLEN),
        .CAUSE_W     (CAUSE_W),
        .FAULT_CAUSE (FAULT_CAUSE)
    ) u_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .trap_valid     (trap_valid),
        .trap_is_irq    (trap_is_irq),
        .trap_cause     (trap_cause),
        .trap_hw_vec    (trap_hw_vec),
        .ctrl_mode      (ctrl_mode),
        .base_pc        (base_pc),
        .slot_addr      (lookup_addr[0]),
        .mem_rvalid     (mem_rvalid),
        .mem_rdata      (mem_rdata),
        .mem_err        (mem_err),
        .busy           (busy),
        .mem_req        (mem_req),
        .mem_addr       (mem_addr),
        .redirect_valid (redirect_valid),
        .redirect_pc    (redirect_pc),
        .redirect_fault (redirect_fault),
        .redirect_cause (redirect_cause)
    );

    // R2
    base_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (redirect_valid && !redirect_fault && !$past(busy)) |-> (redirect_pc[1:0] == 2'b00));
endmodule

// File: tb/trap_vector_unit_test.sv
module trap_vector_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        trap_valid = 0, trap_is_irq = 0, trap_hw_vec = 0;
    logic [11:0] trap_cause = '0;
    logic [7:0]  trap_irq_id = '0;
    logic [31:0] trap_base = '0, vtab_base = '0;
    logic        pend_valid = 0, pend_hw_vec = 0;
    logic [7:0]  pend_irq_id = '0, pend_level = '0, level_thresh = '0;
    logic [31:0] next_entry;
    logic        busy, mem_req;
    logic [31:0] mem_addr;
    logic        mem_rvalid = 0, mem_err = 0;
    logic [31:0] mem_rdata = '0;
    logic        redirect_valid, redirect_fault;
    logic [31:0] redirect_pc;
    logic [11:0] redirect_cause;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    trap_vector_unit uut (
        .clk(clk), .rst_n(rst_n), .trap_valid(trap_valid), .trap_is_irq(trap_is_irq),
        .trap_cause(trap_cause), .trap_irq_id(trap_irq_id), .trap_hw_vec(trap_hw_vec),
        .trap_base(trap_base), .vtab_base(vtab_base), .pend_valid(pend_valid),
        .pend_irq_id(pend_irq_id), .pend_level(pend_level), .pend_hw_vec(pend_hw_vec),
        .level_thresh(level_thresh), .next_entry(next_entry), .busy(busy),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
        .mem_rdata(mem_rdata), .mem_err(mem_err), .redirect_valid(redirect_valid),
        .redirect_pc(redirect_pc), .redirect_fault(redirect_fault),
        .redirect_cause(redirect_cause)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Raise a trap for one cycle; on return outputs from the accepting edge are visible.
    task automatic fire(input bit irq, input logic [11:0] cause, input logic [7:0] id, input bit hv);
        trap_valid = 1; trap_is_irq = irq; trap_cause = cause; trap_irq_id = id; trap_hw_vec = hv;
        @(negedge clk);
        trap_valid = 0;
    endtask

    task automatic t_reset();
        chk("R1 busy", 32'(busy), 0);
        chk("R1 redirect_valid", 32'(redirect_valid), 0);
        chk("R1 mem_req", 32'(mem_req), 0);
    endtask

    task automatic t_exception();
        trap_base = 32'h0000_1003;
        fire(0, 12'd5, 8'd0, 0);
        chk("R2 redirect_valid", 32'(redirect_valid), 1);
        chk("R2 pc", redirect_pc, 32'h0000_1000);
        chk("R2 cause", 32'(redirect_cause), 5);
        chk("R2 fault", 32'(redirect_fault), 0);
        chk("R2 no mem_req", 32'(mem_req), 0);
        @(negedge clk);
        chk("R2 single pulse", 32'(redirect_valid), 0);
    endtask

    task automatic t_sw_irq();
        trap_base = 32'h0000_1003;
        fire(1, 12'h80B, 8'd7, 0);
        chk("R3 redirect_valid", 32'(redirect_valid), 1);
        chk("R3 pc", redirect_pc, 32'h0000_1000);
        chk("R3 cause", 32'(redirect_cause), 32'h80B);
        chk("R3 no mem_req", 32'(mem_req), 0);
        @(negedge clk);
    endtask

    task automatic t_other_modes();
        for (int m = 0; m < 3; m++) begin
            trap_base = 32'h0000_2000 | 32'(m);
            fire(1, 12'h803, 8'd9, 1);
            chk("R4 redirect_valid", 32'(redirect_valid), 1);
            chk("R4 pc", redirect_pc, 32'h0000_2000);
            chk("R4 no mem_req", 32'(mem_req), 0);
            chk("R4 not busy", 32'(busy), 0);
            @(negedge clk);
        end
    endtask

    task automatic t_hw_vec_ok();
        trap_base = 32'h0000_1003;
        vtab_base = 32'h8000_0047;
        fire(1, 12'h815, 8'd5, 1);
        chk("R5 mem_req", 32'(mem_req), 1);
        chk("R5 mem_addr", mem_addr, 32'h8000_0054);
        chk("R8 busy", 32'(busy), 1);
        chk("R5 no early redirect", 32'(redirect_valid), 0);
        @(negedge clk);
        chk("R5 req one cycle", 32'(mem_req), 0);
        // R8: a trap while busy is ignored
        fire(0, 12'd2, 8'd0, 0);
        chk("R8 ignored redirect", 32'(redirect_valid), 0);
        chk("R8 ignored req", 32'(mem_req), 0);
        chk("R8 still busy", 32'(busy), 1);
        mem_rvalid = 1; mem_rdata = 32'h0000_4001; mem_err = 0;
        @(negedge clk);
        mem_rvalid = 0;
        chk("R6 redirect_valid", 32'(redirect_valid), 1);
        chk("R6 pc", redirect_pc, 32'h0000_4000);
        chk("R6 fault", 32'(redirect_fault), 0);
        chk("R6 cause", 32'(redirect_cause), 32'h815);
        chk("R8 busy cleared", 32'(busy), 0);
        @(negedge clk);
        chk("R8 no late redirect", 32'(redirect_valid), 0);
    endtask

    task automatic t_hw_vec_err();
        trap_base = 32'h0000_1003;
        vtab_base = 32'h8000_0040;
        fire(1, 12'h8FF, 8'd255, 1);
        chk("R5 max id addr", mem_addr, 32'h8000_043C);
        mem_rvalid = 1; mem_err = 1; mem_rdata = 32'hDEAD_BEEF;
        @(negedge clk);
        mem_rvalid = 0; mem_err = 0;
        chk("R7 redirect_valid", 32'(redirect_valid), 1);
        chk("R7 pc", redirect_pc, 32'h0000_1000);
        chk("R7 fault", 32'(redirect_fault), 1);
        chk("R7 cause", 32'(redirect_cause), 1);
        @(negedge clk);
    endtask

    task automatic t_next_entry();
        trap_base = 32'h0000_1003;
        vtab_base = 32'h8000_0047;
        pend_valid = 1; pend_irq_id = 8'd3; pend_level = 8'd5; level_thresh = 8'd2; pend_hw_vec = 0;
        #1 chk("R9 slot", next_entry, 32'h8000_004C);
        pend_level = 8'd2;
        #1 chk("R10 equal level", next_entry, 0);
        pend_level = 8'd3;
        #1 chk("R9 one above", next_entry, 32'h8000_004C);
        pend_valid = 0;
        #1 chk("R10 none pending", next_entry, 0);
        pend_valid = 1; pend_hw_vec = 1;
        #1 chk("R11 hw vectored", next_entry, 0);
        pend_hw_vec = 0; trap_base = 32'h0000_1001;
        #1 chk("R10 other mode", next_entry, 0);
        trap_base = 32'h0000_1003;
        @(negedge clk);
    endtask

    initial begin
        repeat (2) @(negedge clk);
        t_reset();
        rst_n = 1;
        @(negedge clk);
        t_exception();
        t_sw_irq();
        t_other_modes();
        t_hw_vec_ok();
        t_hw_vec_err();
        t_next_entry();
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule